// File: doc/BRIEF.md
# Cascadable Four-Function ALU Slice Chain

This block is a datapath arithmetic-logic unit built from identical 4-bit slices joined through their carries. Each slice holds an arithmetic section, a logic section and an output selector. The arithmetic section adds the operands. It can also subtract by flipping every bit of the second operand and injecting a one at the bottom carry. The logic section forms either the bitwise AND or the bitwise XOR. The upper select bit chooses which section reaches the result.

The top instantiates a parameterised number of slices, three by default, for a 12-bit datapath. Only the lowest slice takes its carry-in from the lower select bit. Every higher slice takes the carry-out of the slice below it. The result and the final carry-out are registered once, so a result appears one clock after its operands are presented.

Top module: `alu_chain`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `res_o` and `cout_o` are cleared to 0 at that edge.
- R2: Operands and opcode sampled at one rising edge produce their result on `res_o`/`cout_o` right after that edge, and the result holds until the next edge.
- R3: Opcode 2'b00 (add): `{cout_o, res_o}` equals the full (WIDTH+1)-bit unsigned sum `a_i + b_i`.
- R4: Opcode 2'b01 (subtract): `res_o` equals `a_i - b_i` modulo 2^WIDTH, and `cout_o` is 1 exactly when `a_i >= b_i` as unsigned values (no borrow).
- R5: Opcode 2'b10: `res_o` equals the bitwise AND of `a_i` and `b_i`.
- R6: Opcode 2'b11: `res_o` equals the bitwise XOR of `a_i` and `b_i`.
- R7: For both logic opcodes (upper opcode bit set), `cout_o` is 0 whatever the operands.
- R8: Carries ripple across every slice boundary, so a carry or borrow born in the lowest slice reaches the top bit and `cout_o` (for example 0xFFF + 0x001 gives 0x000 with `cout_o` = 1 at 12 bits).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 2 | Function select: bit 1 picks logic over arithmetic, bit 0 picks subtract/XOR |
| a_i | input | NUM_SLICES*SLICE_W | First operand |
| b_i | input | NUM_SLICES*SLICE_W | Second operand |
| res_o | output | NUM_SLICES*SLICE_W | Registered result |
| cout_o | output | 1 | Registered carry-out of the top slice (0 for logic functions) |

## Verification
The bench targets carries that must cross the 4-bit slice seams, such as 0x00F + 1, 0x0FF + 1 and 0xFFF + 1. A chain wired with a broken or swapped inter-slice carry returns a result missing its upper bits or loses the final carry. Subtraction is driven at equal operands, at zero minus one and at the most negative value minus one. A design that forgets the injected carry would be off by one, and one that inverts the carry sense would report a borrow where there is none. Logic functions are run with all-ones operands that generate carries in the unused arithmetic path, which exposes a carry-out that leaks into the logic modes. Random operands for every function complete the coverage.

// File: rtl/alu_pkg.sv
package alu_pkg;

    // The encoding is behaviour: bit 1 selects logic, bit 0 selects subtract/XOR.
    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_AND = 2'b10,
        OP_XOR = 2'b11
    } alu_op_e;

    localparam int unsigned OP_LOGIC_BIT = 1;
    localparam int unsigned OP_VARIANT_BIT = 0;

endpackage

// File: rtl/alu_arith.sv
// Ripple adder with a conditional one's complement on the second operand.
module alu_arith #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         inv_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    logic [W:0]   carry;
    logic [W-1:0] b_eff;

    assign carry[0] = cin_i;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic half;
        assign b_eff[i]     = b_i[i] ^ inv_i;
        assign half         = a_i[i] ^ b_eff[i];
        assign sum_o[i]     = half ^ carry[i];
        assign carry[i + 1] = (a_i[i] & b_eff[i]) | (half & carry[i]);
    end

    assign cout_o = carry[W];
endmodule

// File: rtl/alu_logic.sv
// Two-function bitwise unit: AND when sel_i is 0, XOR when sel_i is 1.
module alu_logic #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sel_i,
    output logic [W-1:0] res_o
);
    always_comb begin
        if (sel_i) res_o = a_i ^ b_i;
        else       res_o = a_i & b_i;
    end
endmodule

// File: rtl/alu_slice.sv
// One cascadable slice: arithmetic section, logic section, output selector.
module alu_slice
    import alu_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [1:0]   op_i,
    input  logic         cin_i,
    output logic [W-1:0] res_o,
    output logic         cout_o
);
    logic [W-1:0] arith_res;
    logic [W-1:0] logic_res;
    logic         arith_cout;

    alu_arith #(.W(W)) arith_i (
        .a_i    (a_i),
        .b_i    (b_i),
        .inv_i  (op_i[OP_VARIANT_BIT]),
        .cin_i  (cin_i),
        .sum_o  (arith_res),
        .cout_o (arith_cout)
    );

    alu_logic #(.W(W)) logic_i (
        .a_i   (a_i),
        .b_i   (b_i),
        .sel_i (op_i[OP_VARIANT_BIT]),
        .res_o (logic_res)
    );

    always_comb begin
        if (op_i[OP_LOGIC_BIT]) begin
            res_o  = logic_res;
            cout_o = 1'b0;
        end else begin
            res_o  = arith_res;
            cout_o = arith_cout;
        end
    end
endmodule

// File: rtl/alu_chain.sv
// Chain of ALU slices with a registered result.
module alu_chain
    import alu_pkg::*;
#(
    parameter int unsigned SLICE_W    = 4,
    parameter int unsigned NUM_SLICES = 3,
    localparam int unsigned WIDTH     = SLICE_W * NUM_SLICES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] res_o,
    output logic             cout_o
);
    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic             cout;
    } out_t;

    out_t out_d, out_q;

    logic [NUM_SLICES:0] chain_c;
    logic [WIDTH-1:0]    chain_res;

    // Only the lowest slice takes its carry from the select; the rest ripple.
    assign chain_c[0] = op_i[OP_VARIANT_BIT];

    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
        alu_slice #(.W(SLICE_W)) slice_i (
            .a_i    (a_i[s*SLICE_W +: SLICE_W]),
            .b_i    (b_i[s*SLICE_W +: SLICE_W]),
            .op_i   (op_i),
            .cin_i  (chain_c[s]),
            .res_o  (chain_res[s*SLICE_W +: SLICE_W]),
            .cout_o (chain_c[s + 1])
        );
    end

    always_comb begin
        out_d      = out_q;
        out_d.res  = chain_res;
        out_d.cout = chain_c[NUM_SLICES];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign res_o  = out_q.res;
    assign cout_o = out_q.cout;
endmodule

// File: rtl/alu_chain_chk.sv
module alu_chain_chk #(
    parameter int unsigned WIDTH = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       op_i,
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [WIDTH-1:0] res_o,
    input logic             cout_o
);
    logic [WIDTH:0] ref_sum;
    logic [WIDTH:0] ref_diff;

    assign ref_sum  = {1'b0, a_i} + {1'b0, b_i};
    assign ref_diff = {(a_i >= b_i), (a_i - b_i)};

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $rose(rst_n) |-> (res_o == '0 && cout_o == 1'b0)); // R1

    AST_ADD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == 2'b00) |-> {cout_o, res_o} == $past(ref_sum)); // R3

    AST_SUB_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == 2'b01) |-> {cout_o, res_o} == $past(ref_diff)); // R4

    AST_AND_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == 2'b10) |-> res_o == ($past(a_i) & $past(b_i))); // R5

    AST_XOR_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == 2'b11) |-> res_o == ($past(a_i) ^ $past(b_i))); // R6

    AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i[1])) |-> !cout_o); // R7
endmodule

bind alu_chain alu_chain_chk #(.WIDTH(WIDTH)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .op_i   (op_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .res_o  (res_o),
    .cout_o (cout_o)
);

// File: tb/alu_chain_tb_top.sv
module alu_chain_tb_top;
    localparam int unsigned W = 12;

    typedef struct {
        logic [W-1:0] res;
        logic         cout;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   op = 2'b00;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic [W-1:0] res;
    logic         cout;

    int checks = 0;
    int fails  = 0;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    alu_chain dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .op_i   (op),
        .a_i    (a),
        .b_i    (b),
        .res_o  (res),
        .cout_o (cout)
    );

    function automatic exp_t model(input logic [1:0] o, input logic [W-1:0] x,
                                   input logic [W-1:0] y, input string tag);
        exp_t e;
        logic [W:0] wide;
        e.tag = tag;
        case (o)
            2'b00: begin wide = {1'b0, x} + {1'b0, y}; e.res = wide[W-1:0]; e.cout = wide[W]; end
            2'b01: begin e.res = x - y; e.cout = (x >= y); end
            2'b10: begin e.res = x & y; e.cout = 1'b0; end
            default: begin e.res = x ^ y; e.cout = 1'b0; end
        endcase
        return e;
    endfunction

    // Driver: presents one operation, queues its expectation after the capturing edge.
    task automatic drive(input logic [1:0] o, input logic [W-1:0] x,
                         input logic [W-1:0] y, input string tag);
        @(negedge clk);
        op = o; a = x; b = y;
        @(posedge clk);
        exp_q.push_back(model(o, x, y, tag));
    endtask

    // Monitor: one result per cycle, compared away from the active edge.
    always @(negedge clk) begin
        if (exp_q.size() != 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (res !== e.res || cout !== e.cout) begin
                fails++;
                $display("FAIL %s: res=%h cout=%b expected res=%h cout=%b",
                         e.tag, res, cout, e.res, e.cout);
            end
        end
    end

    task automatic finish_run;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #200000;
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        // R1: reset clears outputs, even with live operands applied
        op = 2'b00; a = 12'hFFF; b = 12'h001;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (res !== '0 || cout !== 1'b0) begin
            fails++;
            $display("FAIL R1: res=%h cout=%b expected res=000 cout=0", res, cout);
        end
        rst_n = 1'b1;

        // R2: back-to-back operations each appear exactly one edge later
        drive(2'b00, 12'h123, 12'h456, "R2");
        drive(2'b10, 12'hF0F, 12'h0FF, "R2");

        // R3: add
        drive(2'b00, 12'h000, 12'h000, "R3");
        drive(2'b00, 12'hFFF, 12'hFFF, "R3");
        drive(2'b00, 12'h7A5, 12'h05A, "R3");

        // R8: carries crossing slice boundaries
        drive(2'b00, 12'h00F, 12'h001, "R8");
        drive(2'b00, 12'h0FF, 12'h001, "R8");
        drive(2'b00, 12'hFFF, 12'h001, "R8");
        drive(2'b01, 12'h100, 12'h001, "R8");

        // R4: subtract
        drive(2'b01, 12'h005, 12'h003, "R4");
        drive(2'b01, 12'h003, 12'h005, "R4");
        drive(2'b01, 12'h000, 12'h000, "R4");
        drive(2'b01, 12'h000, 12'h001, "R4");
        drive(2'b01, 12'h800, 12'h001, "R4");
        drive(2'b01, 12'hABC, 12'hABC, "R4");

        // R5, R6, R7: logic functions, including carry-provoking operands
        drive(2'b10, 12'hFFF, 12'hFFF, "R5");
        drive(2'b10, 12'hA5A, 12'h5A5, "R5");
        drive(2'b11, 12'hFFF, 12'hFFF, "R6");
        drive(2'b11, 12'hA5A, 12'h5A5, "R6");
        drive(2'b10, 12'hFFF, 12'h001, "R7");
        drive(2'b11, 12'hFFF, 12'h801, "R7");

        // Random operands for every function
        for (int i = 0; i < 60; i++) begin
            logic [1:0] o;
            o = 2'(i % 4);
            drive(o, W'($urandom), W'($urandom),
                  o == 2'b00 ? "R3" : o == 2'b01 ? "R4" : o == 2'b10 ? "R5" : "R6");
        end

        @(negedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule